// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Controller

This block produces the digital frequency-offset word that steers the fractional control of a spread-spectrum clock synthesizer. Two selection inputs, each of which carries one of three levels (low, middle, high) as a 2-bit code, pick one of nine spread settings. Five of these settings serve a low reference range (25 to 54 MHz) and four serve a high range (50 to 108 MHz). A 3-bit band index narrows the reference frequency within the range that the setting implies. Together they select a total spread, held in units of 0.01 %.

The output is a signed 16-bit offset in units of 0.001 %. It follows a triangle that is centred on zero. It starts each modulation period at minus half the total spread, climbs to plus half, and falls back. One period is 1166 reference clocks for every setting. A new setting or band is only taken at a period boundary, so the output never jumps in the middle of a sweep. An enable input stops the sweep and parks the output at zero.

The offset is a free-running sample stream, one new value per reference clock. It has no valid/ready handshake: the synthesizer consumes every sample, and back-pressure would distort the modulation period. All other pins are plain control levels.

Top module: `ssm_spread_ctrl`

## Requirements
- R1: A selection code decodes as 00 = low, 01 = middle, 10 = high, and 11 is treated exactly like 10.
- R2: With (major, minor) levels, the pairs (M,M), (M,L), (H,L), (L,L), (L,M) use the low-range spread table, and the pairs (H,M), (L,H), (H,H), (M,H) use the high-range table. The spread T in 0.01 % units is taken from the table for the selected band.
- R3: Band indices 0 to 4 select columns in order of rising frequency. Indices 5 to 7 behave as index 4.
- R4: While reset is high, and after it until the first clock edge that sees the enable high, the offset is 0.
- R5: On the first cycle of every period, the offset equals -5*T (in units of 0.001 %).
- R6: At period position p (0 to 1165), the offset is -5T + floor(k*10T/583), where k = p for p <= 583 and k = 1166 - p otherwise. The peak +5T is therefore reached exactly at p = 583.
- R7: The sweep repeats every 1166 clocks, and the minimum recurs exactly 1166 cycles after the previous one.
- R8: A clock edge that sees the enable low makes the offset 0 from the next cycle on. The next edge that sees the enable high starts a fresh period at position 0.
- R9: A change of selection or band within a period has no effect until the next period starts. The new T is sampled on the edge that begins that period.
- R10: Two consecutive offsets within one period differ by at most ceil(10T/583).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_major | input | 2 | First three-level selection code |
| sel_minor | input | 2 | Second three-level selection code |
| band_idx | input | 3 | Reference-frequency band within the implied range |
| sweep_en | input | 1 | High runs the sweep, low holds the offset at zero |
| freq_ofs | output | 16 | Signed offset, 0.001 % units, one sample per clock |

## Verification
The bench goes after the following corner cases:
- **The 11 code.** A decoder that treated 11 as its own level would pick the wrong table row and show a wrong starting minimum.
- **Band indices above 4.** Without the clamp, these would read garbage or zero spread.
- **The exact peak and the turnaround at position 583.** An accumulator that drops its fractional remainder, or steps once too often, misses +5T or overshoots it.
- **Mid-sweep changes of setting and band.** A design that applies them at once shows a step in the middle of the period, and the peak check catches it.
- **Toggling the enable.** The output must park at zero and restart at the minimum; a design that resumed mid-sweep would fail the period-start check.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Three-level selection alphabet
  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MID = 2'd1,
    LVL_HI  = 2'd2
  } lvl_e;

  localparam int NUM_BANDS = 5;
  localparam int NUM_ROWS  = 9;
  localparam int ROW_W     = $clog2(NUM_ROWS);

  // code 11 folds onto high
  function automatic lvl_e code_to_lvl(input logic [1:0] code);
    if (code[1])      return LVL_HI;
    else if (code[0]) return LVL_MID;
    else              return LVL_LO;
  endfunction

endpackage

// File: rtl/ssm_sel_decode.sv
module ssm_sel_decode
  import ssm_pkg::*;
(
  input  logic [1:0]       maj_code,
  input  logic [1:0]       min_code,
  output logic [ROW_W-1:0] row
);

  lvl_e lv_maj, lv_min;

  always_comb begin
    lv_maj = code_to_lvl(maj_code);
    lv_min = code_to_lvl(min_code);
    // rows 0..4: low reference range, rows 5..8: high reference range
    unique case ({lv_maj, lv_min})
      {LVL_MID, LVL_MID}: row = ROW_W'(0);
      {LVL_MID, LVL_LO }: row = ROW_W'(1);
      {LVL_HI , LVL_LO }: row = ROW_W'(2);
      {LVL_LO , LVL_LO }: row = ROW_W'(3);
      {LVL_LO , LVL_MID}: row = ROW_W'(4);
      {LVL_HI , LVL_MID}: row = ROW_W'(5);
      {LVL_LO , LVL_HI }: row = ROW_W'(6);
      {LVL_HI , LVL_HI }: row = ROW_W'(7);
      {LVL_MID, LVL_HI }: row = ROW_W'(8);
      default:            row = ROW_W'(0);
    endcase
  end

endmodule

// File: rtl/ssm_spread_rom.sv
module ssm_spread_rom
  import ssm_pkg::*;
#(
  parameter int SPR_W = 9
) (
  input  logic [ROW_W-1:0] row,
  input  logic [2:0]       band_raw,
  output logic [SPR_W-1:0] spread
);

  localparam int PACK_W = SPR_W * NUM_BANDS;
  localparam int LAST_B = NUM_BANDS - 1;

  // Each row packs five spreads (0.01 % units); band 0 in the low bits.
  function automatic logic [PACK_W-1:0] row_pack(input logic [ROW_W-1:0] r);
    case (r)
      ROW_W'(0): return {SPR_W'(280), SPR_W'(300), SPR_W'(320), SPR_W'(350), SPR_W'(380)};
      ROW_W'(1): return {SPR_W'(240), SPR_W'(260), SPR_W'(280), SPR_W'(300), SPR_W'(320)};
      ROW_W'(2): return {SPR_W'(200), SPR_W'(220), SPR_W'(240), SPR_W'(250), SPR_W'(280)};
      ROW_W'(3): return {SPR_W'(170), SPR_W'(180), SPR_W'(190), SPR_W'(210), SPR_W'(230)};
      ROW_W'(4): return {SPR_W'(140), SPR_W'(150), SPR_W'(160), SPR_W'(170), SPR_W'(190)};
      ROW_W'(5): return {SPR_W'(180), SPR_W'(200), SPR_W'(230), SPR_W'(240), SPR_W'(250)};
      ROW_W'(6): return {SPR_W'(130), SPR_W'(140), SPR_W'(160), SPR_W'(180), SPR_W'(190)};
      ROW_W'(7): return {SPR_W'(80),  SPR_W'(100), SPR_W'(110), SPR_W'(110), SPR_W'(120)};
      ROW_W'(8): return {SPR_W'(60),  SPR_W'(80),  SPR_W'(90),  SPR_W'(90),  SPR_W'(100)};
      default:   return '0;
    endcase
  endfunction

  logic [2:0]        band_c;
  logic [PACK_W-1:0] packed_row;

  always_comb begin
    band_c     = (int'(band_raw) > LAST_B) ? 3'(LAST_B) : band_raw;
    packed_row = row_pack(row);
    spread     = packed_row[int'(band_c)*SPR_W +: SPR_W];
  end

endmodule

// File: rtl/ssm_step_calc.sv
module ssm_step_calc #(
  parameter int SPR_W   = 9,
  parameter int HALF    = 583,
  parameter int HALF_W  = 12,
  parameter int SWING_W = 13,
  parameter int REM_W   = 10
) (
  input  logic [SPR_W-1:0]   spread,
  output logic [HALF_W-1:0]  half_amp,
  output logic [SWING_W-1:0] quo,
  output logic [REM_W-1:0]   rem
);

  logic [SWING_W-1:0] swing;
  logic [SWING_W-1:0] rem_w;

  // 0.01 % -> 0.001 %: half = 5*T, full swing = 10*T
  always_comb begin
    swing    = SWING_W'(spread) * SWING_W'(10);
    half_amp = HALF_W'(spread) * HALF_W'(5);
    quo      = swing / SWING_W'(HALF);
    rem_w    = swing % SWING_W'(HALF);
    rem      = rem_w[REM_W-1:0];
  end

endmodule

// File: rtl/ssm_tri_sweep.sv
module ssm_tri_sweep #(
  parameter int PERIOD  = 1166,
  parameter int HALF_W  = 12,
  parameter int SWING_W = 13,
  parameter int REM_W   = 10,
  parameter int OFS_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [HALF_W-1:0]       half_in,
  input  logic [SWING_W-1:0]      quo_in,
  input  logic [REM_W-1:0]        rem_in,
  output logic signed [OFS_W-1:0] ofs
);

  localparam int HALF = PERIOD / 2;
  localparam int PH_W = $clog2(PERIOD);
  localparam logic [PH_W-1:0]    PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0]    PH_TOP  = PH_W'(HALF);
  localparam logic [PH_W-1:0]    PH_ONE  = PH_W'(1);
  localparam logic [SWING_W-1:0] S_ONE   = SWING_W'(1);
  localparam logic [REM_W:0]     HALF_R  = (REM_W + 1)'(HALF);

  logic [PH_W-1:0]    ph_q;
  logic               run_q;
  logic [SWING_W-1:0] fl_q, fl_nx;
  logic [REM_W-1:0]   rm_q, rm_nx;
  logic [HALF_W-1:0]  half_q;
  logic [SWING_W-1:0] quo_q;
  logic [REM_W-1:0]   rin_q;
  logic [REM_W:0]     up_sum, dn_sum;
  logic               rising;

  // Remainder-tracked accumulator: fl = floor(k * 2H / HALF)
  always_comb begin
    rising = ph_q < PH_TOP;
    up_sum = {1'b0, rm_q} + {1'b0, rin_q};
    dn_sum = {1'b0, rm_q} + HALF_R - {1'b0, rin_q};
    if (rising) begin
      if (up_sum >= HALF_R) begin
        fl_nx = fl_q + quo_q + S_ONE;
        rm_nx = REM_W'(up_sum - HALF_R);
      end else begin
        fl_nx = fl_q + quo_q;
        rm_nx = up_sum[REM_W-1:0];
      end
    end else begin
      if (rm_q >= rin_q) begin
        fl_nx = fl_q - quo_q;
        rm_nx = rm_q - rin_q;
      end else begin
        fl_nx = fl_q - quo_q - S_ONE;
        rm_nx = dn_sum[REM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      run_q  <= 1'b0;
      fl_q   <= '0;
      rm_q   <= '0;
      half_q <= '0;
      quo_q  <= '0;
      rin_q  <= '0;
    end else if (!en) begin
      ph_q  <= '0;
      run_q <= 1'b0;
      fl_q  <= '0;
      rm_q  <= '0;
    end else if (!run_q || ph_q == PH_LAST) begin
      // period boundary: minimum point, settings sampled here only
      ph_q   <= '0;
      run_q  <= 1'b1;
      fl_q   <= '0;
      rm_q   <= '0;
      half_q <= half_in;
      quo_q  <= quo_in;
      rin_q  <= rem_in;
    end else begin
      ph_q <= ph_q + PH_ONE;
      fl_q <= fl_nx;
      rm_q <= rm_nx;
    end
  end

  always_comb begin
    if (run_q) ofs = $signed(OFS_W'(fl_q)) - $signed(OFS_W'(half_q));
    else       ofs = '0;
  end

  AST_SWING_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (fl_q <= {half_q, 1'b0})); // R6
  AST_PEAK_EXACT: assert property (@(posedge clk) disable iff (rst)
    (run_q && ph_q == PH_TOP) |-> (fl_q == {half_q, 1'b0})); // R6
  AST_RISE_MONO: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && rising) |=> (fl_q >= $past(fl_q))); // R6
  AST_HOLD_SETTING: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && ph_q != PH_LAST) |=> $stable(half_q)); // R9
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && ph_q != PH_LAST) |=>
      (((fl_q >= $past(fl_q)) ? (fl_q - $past(fl_q)) : ($past(fl_q) - fl_q))
        <= ($past(quo_q) + S_ONE))); // R10

endmodule

// File: rtl/ssm_spread_ctrl.sv
module ssm_spread_ctrl
  import ssm_pkg::*;
#(
  parameter int PERIOD = 1166,
  parameter int SPR_W  = 9,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              sel_major,
  input  logic [1:0]              sel_minor,
  input  logic [2:0]              band_idx,
  input  logic                    sweep_en,
  output logic signed [OFS_W-1:0] freq_ofs
);

  localparam int HALF    = PERIOD / 2;
  localparam int SWING_W = $clog2(((1 << SPR_W) - 1) * 10 + 1);
  localparam int HALF_W  = SWING_W - 1;
  localparam int REM_W   = $clog2(HALF);

  logic [ROW_W-1:0]   row;
  logic [SPR_W-1:0]   spread;
  logic [HALF_W-1:0]  half_amp;
  logic [SWING_W-1:0] quo;
  logic [REM_W-1:0]   rem;

  ssm_sel_decode u_dec (
    .maj_code (sel_major),
    .min_code (sel_minor),
    .row      (row)
  );

  ssm_spread_rom #(.SPR_W(SPR_W)) u_rom (
    .row      (row),
    .band_raw (band_idx),
    .spread   (spread)
  );

  ssm_step_calc #(
    .SPR_W(SPR_W), .HALF(HALF), .HALF_W(HALF_W),
    .SWING_W(SWING_W), .REM_W(REM_W)
  ) u_step (
    .spread   (spread),
    .half_amp (half_amp),
    .quo      (quo),
    .rem      (rem)
  );

  ssm_tri_sweep #(
    .PERIOD(PERIOD), .HALF_W(HALF_W), .SWING_W(SWING_W),
    .REM_W(REM_W), .OFS_W(OFS_W)
  ) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .en      (sweep_en),
    .half_in (half_amp),
    .quo_in  (quo),
    .rem_in  (rem),
    .ofs     (freq_ofs)
  );

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sweep_en |=> (freq_ofs == '0)); // R8
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (freq_ofs == '0)); // R4

endmodule

// File: tb/sim_ssm_spread_ctrl.sv
`timescale 1ns/1ps
module sim_ssm_spread_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel_major = 2'd1;
  logic [1:0] sel_minor = 2'd1;
  logic [2:0] band_idx = 3'd0;
  logic sweep_en = 1'b0;
  logic signed [15:0] freq_ofs;

  always #2 clk = ~clk;

  ssm_spread_ctrl u0 (
    .clk(clk), .rst(rst), .sel_major(sel_major), .sel_minor(sel_minor),
    .band_idx(band_idx), .sweep_en(sweep_en), .freq_ofs(freq_ofs)
  );

  // spread in 0.01 % indexed by [major_level*3 + minor_level][band], L=0 M=1 H=2
  localparam int TBL [9][5] = '{
    '{230, 210, 190, 180, 170},
    '{190, 170, 160, 150, 140},
    '{190, 180, 160, 140, 130},
    '{320, 300, 280, 260, 240},
    '{380, 350, 320, 300, 280},
    '{100,  90,  90,  80,  60},
    '{280, 250, 240, 220, 200},
    '{250, 240, 230, 200, 180},
    '{120, 110, 110, 100,  80}
  };

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit mrun = 0, ever_en = 0, prev_run = 0;
  int mph = 0, mT = 0, prev_out = 0;

  function automatic int lvl(input logic [1:0] c);
    return c[1] ? 2 : (c[0] ? 1 : 0);
  endfunction

  function automatic int lookup(input logic [1:0] mj, input logic [1:0] mn, input logic [2:0] b);
    int bi;
    bi = (b > 3'd4) ? 4 : int'(b);
    return TBL[lvl(mj)*3 + lvl(mn)][bi];
  endfunction

  function automatic int expval(input bit run, input int ph, input int t);
    int k;
    if (!run) return 0;
    k = (ph <= 583) ? ph : 1166 - ph;
    return -5*t + (k*10*t)/583;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    int o, lim, d;
    @(posedge clk);
    if (rst || !sweep_en) begin
      mrun = 0; mph = 0;
    end else if (!mrun || mph == 1165) begin
      mrun = 1; mph = 0; mT = lookup(sel_major, sel_minor, band_idx);
      ever_en = 1;
    end else begin
      mph++;
    end
    #1;
    o = int'(freq_ofs);
    if (!mrun)          check(ever_en ? "R8" : "R4", o, 0);
    else if (mph == 0)  check("R5", o, -5*mT);
    else                check("R6", o, expval(mrun, mph, mT));
    if (mrun && prev_run && mph != 0) begin
      lim = (10*mT + 582) / 583;
      d = (o > prev_out) ? o - prev_out : prev_out - o;
      check("R10", int'(d <= lim), 1);
    end
    prev_run = mrun;
    prev_out = o;
  endtask

  task automatic restart();
    sweep_en = 1'b0; tick();
    sweep_en = 1'b1; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R7 watchdog actual running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int start_v, n, lenr;
    void'($urandom(32'd1166));
    // R4: reset and post-reset idle
    repeat (4) tick();
    rst = 1'b0;
    repeat (3) tick();
    check("R4", int'(freq_ofs), 0);

    // R1 R2 R3: every code pair and band, period start equals -5T
    for (int mj = 0; mj < 4; mj++)
      for (int mn = 0; mn < 4; mn++)
        for (int b = 0; b < 8; b++) begin
          sweep_en = 1'b0; tick();
          sel_major = 2'(mj); sel_minor = 2'(mn); band_idx = 3'(b);
          sweep_en = 1'b1; tick();
          if (b > 4)                check("R3", int'(freq_ofs), -5*lookup(2'(mj), 2'(mn), 3'(b)));
          else if (mj == 3 || mn == 3) check("R1", int'(freq_ofs), -5*lookup(2'(mj), 2'(mn), 3'(b)));
          else                      check("R2", int'(freq_ofs), -5*TBL[lvl(2'(mj))*3 + lvl(2'(mn))][b]);
        end

    // R7: period length, peak at 583
    sel_major = 2'd1; sel_minor = 2'd1; band_idx = 3'd0;
    restart();
    start_v = int'(freq_ofs);
    check("R5", start_v, -1900);
    repeat (583) tick();
    check("R6", int'(freq_ofs), 1900);
    repeat (582) tick();
    check("R7", int'(int'(freq_ofs) > start_v), 1);
    tick();
    check("R7", int'(freq_ofs), start_v);

    // R9: mid-sweep change deferred to the next period
    repeat (100) tick();
    sel_major = 2'd2; sel_minor = 2'd2; band_idx = 3'd4;
    repeat (483) tick();
    check("R9", int'(freq_ofs), 1900);
    repeat (583) tick();
    check("R9", int'(freq_ofs), -400);

    // R8: disable parks at zero, re-enable restarts at minimum
    repeat (50) tick();
    sweep_en = 1'b0; tick();
    check("R8", int'(freq_ofs), 0);
    tick();
    check("R8", int'(freq_ofs), 0);
    sweep_en = 1'b1; tick();
    check("R8", int'(freq_ofs), -400);

    // random segments
    for (int s = 0; s < 14; s++) begin
      sel_major = 2'($urandom_range(3));
      sel_minor = 2'($urandom_range(3));
      band_idx  = 3'($urandom_range(7));
      sweep_en  = 1'b1;
      lenr = 300 + int'($urandom_range(2500));
      for (int c = 0; c < lenr; c++) begin
        n = int'($urandom_range(999));
        if (n < 3) begin
          sel_major = 2'($urandom_range(3));
          sel_minor = 2'($urandom_range(3));
          band_idx  = 3'($urandom_range(7));
        end else if (n < 5) begin
          sweep_en = ~sweep_en;
        end else if (!sweep_en && n < 200) begin
          sweep_en = 1'b1;
        end
        tick();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule